// File: doc/BRIEF.md
# Double-Buffered Frame Sequencer

This block drives a wireframe renderer one frame at a time. A major machine starts a clear of the back buffer and waits until the clear finishes. It then starts a draw machine. The draw machine first asks for a camera update from the latest controller input. It then walks the scene memory one triangle at a time, and sends each triangle first to the transform stage and then to the wireframe rasterizer. After the last triangle the draw machine reports completion. The major machine then inverts the page-select bit, which swaps the front and back buffers, and it begins the next frame straight away.

The clear unit, the camera update, the transform stage and the rasterizer are all outside this block. Each one is reached through a one-cycle start pulse, and each answers with a one-cycle done pulse. The scene memory is also outside the block. It is read with a one-cycle read strobe and returns the triangle word one cycle later. A triangle word holds three vertices with x, y and z coordinates, so it has nine coordinates in all. Coordinate j sits at bits [j*COORD_W +: COORD_W] and is passed on unchanged. The transform stage returns six screen fields, which are the x and y of each of the three vertices, and these are passed on unchanged to the rasterizer.

Top module: `frame_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after a reset edge, every start output and mem_rd are low and page_sel is 0. clr_start pulses in the first cycle after reset is released.
- R2: Every start output is high for exactly one cycle. No unit receives a second start before it has returned its done.
- R3: After clr_start, no other start and no read is issued until clr_done. cam_start pulses two cycles after clr_done and is the next start issued.
- R4: One cycle after cam_done, mem_rd pulses with mem_addr 0. One cycle after the ras_done of any triangle other than the last, mem_rd pulses with the next address. A frame reads addresses 0 to TRI_COUNT-1 in order, once each.
- R5: xf_start pulses two cycles after mem_rd. At that point xf_tri equals the word that the memory returned in the cycle after mem_rd. xf_tri holds that value until the next triangle is loaded.
- R6: ras_start pulses one cycle after xf_done. ras_pts equals the xf_pts value that was present in the xf_done cycle, and it holds that value while the rasterizer works.
- R7: When ras_done arrives for triangle TRI_COUNT-1, page_sel inverts two cycles later, in the same cycle as the next clr_start. page_sel changes at no other time.
- R8: A done pulse from a unit that is not currently being waited on is ignored. No start and no read follows from it.
- R9: A reset applied in the middle of a frame abandons that frame: every start output is low and page_sel is 0 in the next cycle. The frame that follows reads from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_start | output | 1 | Start pulse for the back-buffer clear |
| clr_done | input | 1 | Clear finished |
| cam_start | output | 1 | Start pulse for the camera update |
| cam_done | input | 1 | Camera update finished |
| mem_rd | output | 1 | Scene memory read strobe |
| mem_addr | output | ADDR_W | Triangle index being read |
| mem_data | input | 9*COORD_W | Triangle word, valid one cycle after mem_rd |
| xf_start | output | 1 | Start pulse for the transform stage |
| xf_tri | output | 9*COORD_W | Triangle handed to the transform stage |
| xf_done | input | 1 | Transform finished |
| xf_pts | input | 6*SCR_W | Screen points, valid with xf_done |
| ras_start | output | 1 | Start pulse for the wireframe rasterizer |
| ras_pts | output | 6*SCR_W | Screen points handed to the rasterizer |
| ras_done | input | 1 | Rasterizer finished |
| page_sel | output | 1 | Selects which buffer is shown; toggles once per frame |

## Verification
Some properties are checked by the bound checker on every cycle: the one-cycle width of clr_start, that no unit is restarted while its previous request is outstanding, that the camera request waits for the clear, that no read happens before the camera update of the current frame, the link between a page flip and draw completion, and the legal address range. Other behaviour can only be shown by the bench scenarios. These are the exact cycle distances between each done and the next request, the in-order walk through the addresses, that the triangle and point words are captured in the right cycle and then held, that stray done pulses are ignored, and that a reset in the middle of a frame brings the sequence back to address 0 and page 0.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    M_IDLE,
    M_CLR,
    M_DRAW
  } major_st_e;

  typedef enum logic [2:0] {
    D_IDLE,
    D_CAM,
    D_FETCH,
    D_LOAD,
    D_XF,
    D_RAS
  } draw_st_e;

  localparam int VERTS_PER_TRI  = 3;
  localparam int COORDS_PER_VTX = 3;
  localparam int PTS_PER_VTX    = 2;

endpackage

// File: rtl/fseq_major.sv
module fseq_major
  import fseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_done,
  input  logic draw_done,
  output logic clr_start,
  output logic draw_go,
  output logic page_sel
);

  major_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= M_IDLE;
      clr_start <= 1'b0;
      draw_go   <= 1'b0;
      page_sel  <= 1'b0;
    end else begin
      clr_start <= 1'b0;
      draw_go   <= 1'b0;
      case (st_q)
        M_IDLE: begin
          clr_start <= 1'b1;
          st_q      <= M_CLR;
        end
        M_CLR: begin
          if (clr_done) begin
            draw_go <= 1'b1;
            st_q    <= M_DRAW;
          end
        end
        M_DRAW: begin
          if (draw_done) begin
            page_sel  <= ~page_sel;
            clr_start <= 1'b1;
            st_q      <= M_CLR;
          end
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_draw.sv
module fseq_draw
  import fseq_pkg::*;
#(
  parameter int TRI_COUNT = 64,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              draw_go,
  input  logic              cam_done,
  input  logic              xf_done,
  input  logic              ras_done,
  output logic              cam_start,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              xf_start,
  output logic              ras_start,
  output logic              draw_done,
  output logic              cap_tri,
  output logic              cap_pts
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TRI_COUNT - 1);

  draw_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              at_last;

  assign at_last  = (addr_q == LAST_ADDR);
  assign mem_addr = addr_q;
  assign cap_tri  = (st_q == D_LOAD);
  assign cap_pts  = (st_q == D_XF) && xf_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= D_IDLE;
      addr_q    <= '0;
      cam_start <= 1'b0;
      mem_rd    <= 1'b0;
      xf_start  <= 1'b0;
      ras_start <= 1'b0;
      draw_done <= 1'b0;
    end else begin
      cam_start <= 1'b0;
      mem_rd    <= 1'b0;
      xf_start  <= 1'b0;
      ras_start <= 1'b0;
      draw_done <= 1'b0;
      case (st_q)
        D_IDLE: begin
          if (draw_go) begin
            cam_start <= 1'b1;
            addr_q    <= '0;
            st_q      <= D_CAM;
          end
        end
        D_CAM: begin
          if (cam_done) begin
            mem_rd <= 1'b1;
            st_q   <= D_FETCH;
          end
        end
        D_FETCH: st_q <= D_LOAD;
        D_LOAD: begin
          xf_start <= 1'b1;
          st_q     <= D_XF;
        end
        D_XF: begin
          if (xf_done) begin
            ras_start <= 1'b1;
            st_q      <= D_RAS;
          end
        end
        D_RAS: begin
          if (ras_done) begin
            if (at_last) begin
              draw_done <= 1'b1;
              st_q      <= D_IDLE;
            end else begin
              addr_q <= addr_q + 1'b1;
              mem_rd <= 1'b1;
              st_q   <= D_FETCH;
            end
          end
        end
        default: st_q <= D_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_hold.sv
module fseq_hold #(
  parameter  int FIELDS = 9,
  parameter  int FW     = 17,
  localparam int W      = FIELDS * FW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar f = 0; f < FIELDS; f++) begin : g_fld
    logic [FW-1:0] fld_q;
    always_ff @(posedge clk) begin
      if (rst)       fld_q <= '0;
      else if (load) fld_q <= d[f*FW +: FW];
    end
    assign q[f*FW +: FW] = fld_q;
  end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import fseq_pkg::*;
#(
  parameter  int TRI_COUNT = 64,
  parameter  int COORD_W   = 17,
  parameter  int SCR_W     = 11,
  localparam int ADDR_W    = (TRI_COUNT > 1) ? $clog2(TRI_COUNT) : 1,
  localparam int TRI_FLDS  = VERTS_PER_TRI * COORDS_PER_VTX,
  localparam int PTS_FLDS  = VERTS_PER_TRI * PTS_PER_VTX,
  localparam int TRI_W     = TRI_FLDS * COORD_W,
  localparam int PTS_W     = PTS_FLDS * SCR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              clr_start,
  input  logic              clr_done,
  output logic              cam_start,
  input  logic              cam_done,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [TRI_W-1:0]  mem_data,
  output logic              xf_start,
  output logic [TRI_W-1:0]  xf_tri,
  input  logic              xf_done,
  input  logic [PTS_W-1:0]  xf_pts,
  output logic              ras_start,
  output logic [PTS_W-1:0]  ras_pts,
  input  logic              ras_done,
  output logic              page_sel
);

  logic draw_go;
  logic draw_done;
  logic cap_tri;
  logic cap_pts;

  fseq_major u_major (
    .clk       (clk),
    .rst       (rst),
    .clr_done  (clr_done),
    .draw_done (draw_done),
    .clr_start (clr_start),
    .draw_go   (draw_go),
    .page_sel  (page_sel)
  );

  fseq_draw #(
    .TRI_COUNT (TRI_COUNT),
    .ADDR_W    (ADDR_W)
  ) u_draw (
    .clk       (clk),
    .rst       (rst),
    .draw_go   (draw_go),
    .cam_done  (cam_done),
    .xf_done   (xf_done),
    .ras_done  (ras_done),
    .cam_start (cam_start),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .xf_start  (xf_start),
    .ras_start (ras_start),
    .draw_done (draw_done),
    .cap_tri   (cap_tri),
    .cap_pts   (cap_pts)
  );

  fseq_hold #(
    .FIELDS (TRI_FLDS),
    .FW     (COORD_W)
  ) u_tri_hold (
    .clk  (clk),
    .rst  (rst),
    .load (cap_tri),
    .d    (mem_data),
    .q    (xf_tri)
  );

  fseq_hold #(
    .FIELDS (PTS_FLDS),
    .FW     (SCR_W)
  ) u_pts_hold (
    .clk  (clk),
    .rst  (rst),
    .load (cap_pts),
    .d    (xf_pts),
    .q    (ras_pts)
  );

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int TRI_COUNT = 64,
  parameter int ADDR_W    = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_start,
  input logic              clr_done,
  input logic              cam_start,
  input logic              cam_done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              xf_start,
  input logic              xf_done,
  input logic              ras_start,
  input logic              ras_done,
  input logic              page_sel,
  input logic              draw_done
);

  logic clr_busy, cam_busy, xf_busy, ras_busy, cam_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_busy <= 1'b0;
      cam_busy <= 1'b0;
      xf_busy  <= 1'b0;
      ras_busy <= 1'b0;
      cam_seen <= 1'b0;
    end else begin
      if (clr_start)     clr_busy <= 1'b1;
      else if (clr_done) clr_busy <= 1'b0;
      if (cam_start)     cam_busy <= 1'b1;
      else if (cam_done) cam_busy <= 1'b0;
      if (xf_start)      xf_busy  <= 1'b1;
      else if (xf_done)  xf_busy  <= 1'b0;
      if (ras_start)     ras_busy <= 1'b1;
      else if (ras_done) ras_busy <= 1'b0;
      if (clr_start)                 cam_seen <= 1'b0;
      else if (cam_done && cam_busy) cam_seen <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cam_start && !mem_rd && !xf_start && !ras_start && !page_sel);

  // R2
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    clr_start |=> !clr_start);

  // R2
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr_start |-> !clr_busy);

  // R2
  cam_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cam_start |-> !cam_busy);

  // R2
  xf_restart_chk: assert property (@(posedge clk) disable iff (rst)
    xf_start |-> !xf_busy);

  // R2
  ras_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ras_start |-> !ras_busy && !xf_busy);

  // R3
  cam_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cam_start |-> !clr_busy);

  // R3
  read_after_cam_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> cam_seen && !clr_busy);

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (int'(mem_addr) < TRI_COUNT));

  // R5
  xf_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    xf_start |-> $past(mem_rd, 2));

  // R6
  ras_after_xf_chk: assert property (@(posedge clk) disable iff (rst)
    ras_start |-> $past(xf_done));

  // R7
  flip_after_draw_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(page_sel) |-> $past(draw_done));

  // R7
  flip_with_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(page_sel) |-> clr_start);

endmodule

bind frame_sequencer fseq_chk #(
  .TRI_COUNT (TRI_COUNT),
  .ADDR_W    (ADDR_W)
) u_fseq_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_start (clr_start),
  .clr_done  (clr_done),
  .cam_start (cam_start),
  .cam_done  (cam_done),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .xf_start  (xf_start),
  .xf_done   (xf_done),
  .ras_start (ras_start),
  .ras_done  (ras_done),
  .page_sel  (page_sel),
  .draw_done (draw_done)
);

// File: tb/test_frame_sequencer.sv
`timescale 1ns/1ps
module test_frame_sequencer;

  localparam int TRIS = 5;
  localparam int CW   = 17;
  localparam int SW   = 11;
  localparam int AW   = $clog2(TRIS);
  localparam int TW   = 9 * CW;
  localparam int PW   = 6 * SW;

  localparam int S_RAS = 0;
  localparam int S_XF  = 1;
  localparam int S_RD  = 2;
  localparam int S_CAM = 3;
  localparam int S_CLR = 4;

  // clear lat, camera lat, transform lat, raster lat, frames, stray dones
  localparam int VEC [4][6] = '{
    '{1, 1, 1, 1, 2, 0},
    '{3, 2, 4, 1, 1, 1},
    '{1, 5, 1, 3, 2, 1},
    '{2, 1, 2, 2, 2, 0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          clr_start, cam_start, mem_rd, xf_start, ras_start, page_sel;
  logic          clr_done, cam_done, xf_done, ras_done;
  logic [AW-1:0] mem_addr;
  logic [TW-1:0] mem_data;
  logic [TW-1:0] xf_tri;
  logic [PW-1:0] xf_pts;
  logic [PW-1:0] ras_pts;

  int   vecs = 0;
  int   bad  = 0;
  logic exp_page;

  always #2.5 clk = ~clk;

  frame_sequencer #(
    .TRI_COUNT (TRIS),
    .COORD_W   (CW),
    .SCR_W     (SW)
  ) i_frame_sequencer (
    .clk       (clk),
    .rst       (rst),
    .clr_start (clr_start),
    .clr_done  (clr_done),
    .cam_start (cam_start),
    .cam_done  (cam_done),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .xf_start  (xf_start),
    .xf_tri    (xf_tri),
    .xf_done   (xf_done),
    .xf_pts    (xf_pts),
    .ras_start (ras_start),
    .ras_pts   (ras_pts),
    .ras_done  (ras_done),
    .page_sel  (page_sel)
  );

  function automatic logic [TW-1:0] tri_of(int k);
    logic [TW-1:0] r;
    for (int j = 0; j < 9; j++) r[j*CW +: CW] = CW'((k * 9 + j) * 113 + 7);
    return r;
  endfunction

  function automatic logic [PW-1:0] pts_of(int k);
    logic [PW-1:0] r;
    for (int j = 0; j < 6; j++) r[j*SW +: SW] = SW'((k * 6 + j) * 29 + 3);
    return r;
  endfunction

  // scene memory model, one-cycle read latency; garbage when not read
  always_ff @(posedge clk)
    mem_data <= mem_rd ? tri_of(int'(mem_addr)) : ~tri_of(int'(mem_addr));

  function automatic logic [4:0] starts();
    return {clr_start, cam_start, mem_rd, xf_start, ras_start};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [TW-1:0] act, input logic [TW-1:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_dones();
    clr_done = 1'b0;
    cam_done = 1'b0;
    xf_done  = 1'b0;
    ras_done = 1'b0;
    xf_pts   = '1;
  endtask

  task automatic set_done(input int idx);
    case (idx)
      S_CLR:   clr_done = 1'b1;
      S_CAM:   cam_done = 1'b1;
      S_XF:    xf_done  = 1'b1;
      default: ras_done = 1'b1;
    endcase
  endtask

  // expects start 'idx' exactly 'gap' cycles after the current negedge
  task automatic wait_for(input int idx, input int gap, input bit flip, input string req);
    bit noisy = 1'b0;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      clear_dones();
      if (i < gap && (starts() != 5'b0 || page_sel != exp_page)) noisy = 1'b1;
    end
    if (flip) exp_page = ~exp_page;
    check(!noisy && starts() == 5'(1 << idx) && page_sel == exp_page, req,
          TW'({noisy, starts(), page_sel}), TW'({1'b0, 5'(1 << idx), exp_page}));
  endtask

  // holds the unit busy for 'lat' cycles, outputs must stay quiet, then drives done
  task automatic give_done(input int idx, input int lat, input bit spur, input string req);
    bit noisy = 1'b0;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      clear_dones();
      if (starts() != 5'b0 || page_sel != exp_page) noisy = 1'b1;
      if (spur && i == 1 && lat >= 2) begin
        for (int u = 0; u < 5; u++)
          if (u != idx && u != S_RD) set_done(u);
      end
    end
    check(!noisy, spur ? "R8: stray done pulses ignored" : req,
          TW'(noisy), TW'(0));
    set_done(idx);
  endtask

  task automatic run_frame(input int cl, input int cm, input int xl, input int rl,
                           input int clr_gap, input bit flip, input bit spur);
    if (flip) wait_for(S_CLR, clr_gap, 1'b1, "R7: page flip with next clear");
    else      wait_for(S_CLR, clr_gap, 1'b0, "R1: clear right after reset");
    give_done(S_CLR, cl, spur, "R3: quiet until clear done");
    wait_for(S_CAM, 2, 1'b0, "R3: camera request after clear");
    give_done(S_CAM, cm, spur, "R2: quiet during camera update");
    for (int k = 0; k < TRIS; k++) begin
      wait_for(S_RD, 1, 1'b0, "R4: read follows previous done");
      check(int'(mem_addr) == k, "R4: sequential address",
            TW'(mem_addr), TW'(k));
      wait_for(S_XF, 2, 1'b0, "R5: transform two cycles after read");
      check(xf_tri == tri_of(k), "R5: triangle word", xf_tri, tri_of(k));
      give_done(S_XF, xl, spur, "R2: single transform start");
      xf_pts = pts_of(k);
      check(xf_tri == tri_of(k), "R5: triangle word held", xf_tri, tri_of(k));
      wait_for(S_RAS, 1, 1'b0, "R6: raster one cycle after transform");
      check(ras_pts == pts_of(k), "R6: screen points", TW'(ras_pts), TW'(pts_of(k)));
      give_done(S_RAS, rl, spur, "R2: single raster start");
      check(ras_pts == pts_of(k), "R6: screen points held", TW'(ras_pts), TW'(pts_of(k)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    bit first = 1'b1;
    rst = 1'b1;
    exp_page = 1'b0;
    clear_dones();
    repeat (3) @(negedge clk);
    check(starts() == 5'b0 && page_sel == 1'b0, "R1: quiet in reset",
          TW'({starts(), page_sel}), TW'(0));
    rst = 1'b0;

    for (int v = 0; v < 4; v++) begin
      for (int f = 0; f < VEC[v][4]; f++) begin
        run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                  first ? 1 : 2, !first, VEC[v][5] != 0);
        first = 1'b0;
      end
    end

    // R9: reset in the middle of a frame while page_sel is 1
    wait_for(S_CLR, 2, 1'b1, "R7: page flip with next clear");
    check(page_sel == 1'b1, "R7: page after odd frame count",
          TW'(page_sel), TW'(1));
    give_done(S_CLR, 2, 1'b0, "R3: quiet until clear done");
    wait_for(S_CAM, 2, 1'b0, "R3: camera request after clear");
    give_done(S_CAM, 1, 1'b0, "R2: quiet during camera update");
    wait_for(S_RD, 1, 1'b0, "R4: read follows camera done");
    wait_for(S_XF, 2, 1'b0, "R5: transform two cycles after read");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(starts() == 5'b0 && page_sel == 1'b0, "R9: mid-frame reset clears",
          TW'({starts(), page_sel}), TW'(0));
    @(negedge clk);
    rst = 1'b0;
    exp_page = 1'b0;
    run_frame(2, 2, 2, 2, 1, 1'b0, 1'b0);
    wait_for(S_CLR, 2, 1'b1, "R7: page flip after restarted frame");
    check(page_sel == 1'b1, "R9: first frame after reset flips once",
          TW'(page_sel), TW'(1));

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule